// File: doc/BRIEF.md
# Digital Back-Porch Clamp

This block fixes the blanking level of an 8-bit composite video sample stream. On every line, a marker input flags the back-porch interval. Inside that interval the block averages the first sixteen valid samples. It then smooths that per-line level with a first-order recursive filter, so that small line-to-line differences do not show up as horizontal streaks. Every sample is shifted by the filtered level so that the back porch always lands on a fixed code. That code depends on the colour standard: 3Ch for NTSC and 40h for PAL.

When the clamp is off, samples pass through unchanged, with the same latency. The measurement is sequenced by a three-state machine:

- MS_WAIT waits for the first valid sample inside the window. On it, the transition `start` leads to MS_ACCUM.
- MS_ACCUM sums samples. It has two exits:
  - `complete` leads to MS_HOLD on the sixteenth sample and issues one filter update.
  - `abort` leads back to MS_WAIT if the window closes early; no update is issued.
- MS_HOLD ignores the rest of the window. `release` leads back to MS_WAIT when the window drops.

The filter estimate keeps 4 fractional bits. The integer part of the estimate is the porch level subtracted from each sample.

Top module: `porch_clamp`

## Requirements
- R1: With `clamp_en` low, `pix_out` equals the `pix_in` value presented two clocks earlier.
- R2: With `clamp_en` high, `pix_out` = saturate(`pix_in` − P + T). P is the integer part (bits 11:4) of the 12-bit filter estimate at the time the sample is taken. T is the target code.
- R3: T is 3Ch when `pal_sel` is 0 and 40h when `pal_sel` is 1.
- R4: Reset (synchronous, `rst_n` low across a clock edge) loads the estimate with T·16, using the `pal_sel` value at reset. Until the first line update, a clamped sample therefore comes out unchanged. During reset, `out_vld` and `pix_out` are 0.
- R5: A line measurement is the sum of the first 16 samples with `pix_vld` and `porch_win` both high, shifted right by 4. Window cycles with `pix_vld` low are not counted.
- R6: If `porch_win` falls before 16 samples have been taken, the estimate does not change.
- R7: Each completed measurement M updates the estimate E once: E ← E + floor((16·M − E)/8).
- R8: The clamped result saturates to 00h below zero and to FFh above 255.
- R9: `out_vld` equals `pix_vld` delayed by exactly two clocks. Each output sample corresponds to one input sample, in order.
- R10: Samples in the window after the sixteenth do not affect the measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_in | input | 8 | Digitized composite sample |
| pix_vld | input | 1 | Sample strobe |
| porch_win | input | 1 | High during the back-porch interval |
| pal_sel | input | 1 | 0 = NTSC target 3Ch, 1 = PAL target 40h |
| clamp_en | input | 1 | 1 = apply clamp, 0 = pass through |
| pix_out | output | 8 | Corrected sample |
| out_vld | output | 1 | Strobe for `pix_out` |

## Verification
The full input code range is swept, both clamped and bypassed, right after reset in each standard. This separates the offset arithmetic from pass-through, because the output must equal the input there. Runs of porch lines at a raised level (NTSC) and at a lowered level (PAL) move the estimate step by step. Full sweeps after those runs hit saturation at the low and the high end respectively. Three window variants then tell apart sample selection from filtering:
- a window that closes early (no update);
- a window with invalid cycles inside it (those cycles must not count);
- a window that runs past sixteen samples with extreme values in the tail (the tail must not count).

Idle cycles inside the sweeps check the valid-strobe delay.

// File: rtl/porch_clamp_pkg.sv
package porch_clamp_pkg;

    typedef enum logic [1:0] {
        MS_WAIT  = 2'd0,
        MS_ACCUM = 2'd1,
        MS_HOLD  = 2'd2
    } meter_state_t;

    localparam logic [7:0] NTSC_LEVEL = 8'h3C;
    localparam logic [7:0] PAL_LEVEL  = 8'h40;

    function automatic logic [7:0] level_for(input logic pal);
        return pal ? PAL_LEVEL : NTSC_LEVEL;
    endfunction

endpackage

// File: rtl/porch_meter.sv
module porch_meter
    import porch_clamp_pkg::*;
#(
    parameter int DW       = 8,
    parameter int AVG_LOG2 = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] smp,
    input  logic          smp_vld,
    input  logic          win,
    output logic          meas_stb,
    output logic [DW-1:0] meas
);
    localparam int NAVG = 1 << AVG_LOG2;
    localparam int AW   = DW + AVG_LOG2;
    localparam logic [AVG_LOG2-1:0] LAST_CNT = AVG_LOG2'(NAVG - 1);

    meter_state_t         state_q;
    meter_state_t         state_d;
    logic [AW-1:0]        acc_q;
    logic [AVG_LOG2-1:0]  cnt_q;
    logic                 take;
    logic                 last;
    logic [AW-1:0]        acc_sum;

    assign take    = smp_vld && win;
    assign last    = (cnt_q == LAST_CNT);
    assign acc_sum = acc_q + AW'(smp);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= MS_WAIT;
        else        state_q <= state_d;
    end

    // transitions: start, complete, abort, release
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MS_WAIT:  if (take) state_d = MS_ACCUM;
            MS_ACCUM: begin
                if (!win)              state_d = MS_WAIT;
                else if (take && last) state_d = MS_HOLD;
            end
            MS_HOLD:  if (!win) state_d = MS_WAIT;
            default:  state_d = MS_WAIT;
        endcase
    end

    // accumulator and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q    <= '0;
            cnt_q    <= '0;
            meas_stb <= 1'b0;
            meas     <= '0;
        end else begin
            meas_stb <= 1'b0;
            unique case (state_q)
                MS_WAIT: begin
                    if (take) begin
                        acc_q <= AW'(smp);
                        cnt_q <= AVG_LOG2'(1);
                    end
                end
                MS_ACCUM: begin
                    if (win && take) begin
                        acc_q <= acc_sum;
                        cnt_q <= cnt_q + 1'b1;
                        if (last) begin
                            meas_stb <= 1'b1;
                            meas     <= acc_sum[AW-1:AVG_LOG2];
                        end
                    end
                end
                MS_HOLD: begin
                    cnt_q <= '0;
                end
                default: begin
                    cnt_q <= '0;
                end
            endcase
        end
    end

    // R6: an early window close never yields a measurement
    a_r6_abort_no_update: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MS_ACCUM && !win) |=> !meas_stb);

    // R10: nothing in the hold phase produces another measurement
    a_r10_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MS_HOLD) |=> !meas_stb);

    // R5: a measurement only follows a sample taken during accumulation
    a_r5_stb_source: assert property (@(posedge clk) disable iff (!rst_n)
        meas_stb |-> ($past(state_q) == MS_ACCUM && $past(take)));

endmodule

// File: rtl/porch_filter.sv
module porch_filter #(
    parameter int DW   = 8,
    parameter int FRAC = 4,
    parameter int KSH  = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] tgt,
    input  logic          upd,
    input  logic [DW-1:0] meas,
    output logic [DW-1:0] porch
);
    localparam int EW = DW + FRAC;
    localparam int SW = EW + 2;

    logic [EW-1:0]        est_q;
    logic signed [SW-1:0] diff;
    logic signed [SW-1:0] step;
    logic signed [SW-1:0] est_n;

    always_comb begin
        diff  = $signed({2'b00, meas, {FRAC{1'b0}}}) - $signed({2'b00, est_q});
        step  = diff >>> KSH;
        est_n = $signed({2'b00, est_q}) + step;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)   est_q <= {tgt, {FRAC{1'b0}}};
        else if (upd) est_q <= est_n[EW-1:0];
    end

    assign porch = est_q[EW-1:FRAC];

    // R7: estimate moves only on a measurement strobe
    a_r7_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(est_q));

endmodule

// File: rtl/clamp_path.sv
module clamp_path #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] smp,
    input  logic          smp_vld,
    input  logic          en,
    input  logic [DW-1:0] tgt,
    input  logic [DW-1:0] porch,
    output logic [DW-1:0] y,
    output logic          y_vld
);
    localparam int XW = DW + 2;
    localparam logic signed [XW-1:0] MAXV = XW'((1 << DW) - 1);

    logic [DW-1:0]        s1_smp;
    logic [DW-1:0]        s1_tgt;
    logic [DW-1:0]        s1_porch;
    logic                 s1_vld;
    logic                 s1_en;
    logic signed [XW-1:0] shifted;
    logic [DW-1:0]        clipped;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_smp   <= '0;
            s1_tgt   <= '0;
            s1_porch <= '0;
            s1_vld   <= 1'b0;
            s1_en    <= 1'b0;
        end else begin
            s1_smp   <= smp;
            s1_tgt   <= tgt;
            s1_porch <= porch;
            s1_vld   <= smp_vld;
            s1_en    <= en;
        end
    end

    always_comb begin
        shifted = $signed({2'b00, s1_smp}) - $signed({2'b00, s1_porch})
                + $signed({2'b00, s1_tgt});
        if (shifted < 0)         clipped = '0;
        else if (shifted > MAXV) clipped = '1;
        else                     clipped = shifted[DW-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            y     <= '0;
            y_vld <= 1'b0;
        end else begin
            y     <= s1_en ? clipped : s1_smp;
            y_vld <= s1_vld;
        end
    end

    // R9: valid strobe runs through both stages
    a_r9_stage_one: assert property (@(posedge clk) disable iff (!rst_n)
        smp_vld |=> s1_vld);
    a_r9_stage_two: assert property (@(posedge clk) disable iff (!rst_n)
        s1_vld |=> y_vld);
    // R1: bypass returns the sample two clocks later
    a_r1_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && !en) |-> ##2 (y == $past(smp, 2)));

endmodule

// File: rtl/porch_clamp.sv
module porch_clamp
    import porch_clamp_pkg::*;
#(
    parameter int DW       = 8,
    parameter int AVG_LOG2 = 4,
    parameter int FRAC     = 4,
    parameter int KSH      = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] pix_in,
    input  logic          pix_vld,
    input  logic          porch_win,
    input  logic          pal_sel,
    input  logic          clamp_en,
    output logic [DW-1:0] pix_out,
    output logic          out_vld
);
    logic [DW-1:0] tgt;
    logic          meas_stb;
    logic [DW-1:0] meas;
    logic [DW-1:0] porch;

    assign tgt = DW'(level_for(pal_sel));

    porch_meter #(.DW(DW), .AVG_LOG2(AVG_LOG2)) u_meter (
        .clk(clk), .rst_n(rst_n), .smp(pix_in), .smp_vld(pix_vld),
        .win(porch_win), .meas_stb(meas_stb), .meas(meas)
    );

    porch_filter #(.DW(DW), .FRAC(FRAC), .KSH(KSH)) u_filter (
        .clk(clk), .rst_n(rst_n), .tgt(tgt), .upd(meas_stb),
        .meas(meas), .porch(porch)
    );

    clamp_path #(.DW(DW)) u_path (
        .clk(clk), .rst_n(rst_n), .smp(pix_in), .smp_vld(pix_vld),
        .en(clamp_en), .tgt(tgt), .porch(porch), .y(pix_out), .y_vld(out_vld)
    );

    // R9: output strobe never appears without an input two clocks back
    a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_vld |-> ##2 !out_vld);

endmodule

// File: tb/porch_clamp_test.sv
module porch_clamp_test;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] pix_in;
    logic       pix_vld, porch_win, pal_sel, clamp_en;
    wire  [7:0] pix_out;
    wire        out_vld;

    always #10 clk = ~clk;

    porch_clamp uut (
        .clk(clk), .rst_n(rst_n), .pix_in(pix_in), .pix_vld(pix_vld),
        .porch_win(porch_win), .pal_sel(pal_sel), .clamp_en(clamp_en),
        .pix_out(pix_out), .out_vld(out_vld)
    );

    int    n_checks = 0;
    int    n_err    = 0;
    string cur_req  = "R4";
    int    exp_q[$];
    logic  vh1 = 1'b0, vh2 = 1'b0;
    int    est = 0;
    int    tgt = 0;
    bit    done = 0;

    task automatic check(input bit ok, input string what, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d", cur_req, what, act, expv);
        end
    endtask

    function automatic int exp_out(input int v, input bit en);
        int r;
        if (!en) return v;
        r = v - (est >> 4) + tgt;
        if (r < 0) r = 0;
        if (r > 255) r = 255;
        return r;
    endfunction

    task automatic step(input logic vld, input logic win, input int v, input bit en, input bit dc);
        @(negedge clk);
        check(out_vld === vh2, "R9 out_vld", int'(out_vld), int'(vh2));
        if (out_vld === 1'b1) begin
            if (exp_q.size() == 0) check(0, "R9 extra output", int'(pix_out), -1);
            else begin
                int e = exp_q.pop_front();
                if (e >= 0) check(int'(pix_out) == e, "pix_out", int'(pix_out), e);
            end
        end
        vh2 = vh1;
        vh1 = vld;
        pix_vld   = vld;
        porch_win = win;
        pix_in    = v[7:0];
        clamp_en  = en;
        if (vld) exp_q.push_back(dc ? -1 : exp_out(v, en));
    endtask

    task automatic do_reset(input bit pal);
        @(negedge clk);
        rst_n = 1'b0; pal_sel = pal; pix_vld = 1'b0; porch_win = 1'b0;
        pix_in = 8'h00; clamp_en = 1'b1;
        repeat (3) @(negedge clk);
        cur_req = "R4";
        check(out_vld === 1'b0, "R4 reset out_vld", int'(out_vld), 0);
        check(pix_out === 8'h00, "R4 reset pix_out", int'(pix_out), 0);
        tgt = pal ? 8'h40 : 8'h3C;
        est = tgt * 16;
        vh1 = 1'b0; vh2 = 1'b0;
        exp_q.delete();
        rst_n = 1'b1;
    endtask

    task automatic flush();
        repeat (3) step(1'b0, 1'b0, 0, 1'b1, 1'b1);
        check(exp_q.size() == 0, "R9 leftover samples", exp_q.size(), 0);
    endtask

    task automatic sweep(input bit en, input int stride);
        for (int v = 0; v < 256; v += stride) begin
            if (v % 7 == 3) step(1'b0, 1'b0, 8'hAA, en, 1'b1);
            step(1'b1, 1'b0, v, en, 1'b0);
        end
        flush();
    endtask

    // n window cycles carrying samples, an invalid cycle every gap_every, tail value after 16
    task automatic porch_line(input int base, input int n, input int gap_every, input int tail);
        int taken = 0;
        int sum = 0;
        for (int i = 0; i < n; i++) begin
            int v = (taken < 16) ? base + (taken % 4) : tail;
            if (gap_every > 0 && (i % gap_every) == gap_every - 1)
                step(1'b0, 1'b1, 255, 1'b1, 1'b1);
            step(1'b1, 1'b1, v, 1'b1, 1'b1);
            if (taken < 16) sum += v;
            taken++;
        end
        repeat (3) step(1'b0, 1'b0, 0, 1'b1, 1'b1);
        if (taken >= 16) begin
            int m = sum >> 4;
            int d = m * 16 - est;
            est = est + (d >>> 3);
        end
    endtask

    task automatic probe();
        step(1'b1, 1'b0, 8'h00, 1'b1, 1'b0);
        step(1'b1, 1'b0, 8'h20, 1'b1, 1'b0);
        step(1'b1, 1'b0, 8'h80, 1'b1, 1'b0);
        step(1'b1, 1'b0, 8'hFF, 1'b1, 1'b0);
        flush();
    endtask

    initial begin : watchdog
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_checks++;
                n_err++;
                $display("FAIL R9 watchdog expired actual=%0d expected=%0d", cyc, 150000);
                $display("Result: errors=%0d of %0d checks", n_err, n_checks);
                $finish;
            end
        end
    end

    initial begin
        rst_n = 1'b0; pal_sel = 1'b0; pix_vld = 1'b0; porch_win = 1'b0;
        pix_in = 8'h00; clamp_en = 1'b0;

        // NTSC: reset estimate gives identity, bypass is identity
        do_reset(1'b0);
        cur_req = "R4 R3"; sweep(1'b1, 1);
        cur_req = "R1";    sweep(1'b0, 1);

        // raised porch, line by line filter steps
        cur_req = "R7 R5";
        for (int k = 0; k < 12; k++) begin
            porch_line(8'h50, 16, 0, 0);
            probe();
        end
        cur_req = "R2 R8"; sweep(1'b1, 1);
        cur_req = "R1";    sweep(1'b0, 5);

        // early close: no update
        cur_req = "R6";
        porch_line(8'hA0, 10, 0, 0);
        probe();
        porch_line(8'h00, 15, 0, 0);
        probe();

        // invalid cycles inside window are skipped
        cur_req = "R5";
        porch_line(8'h30, 16, 3, 0);
        probe();
        porch_line(8'h30, 16, 2, 0);
        probe();

        // tail after 16 samples is ignored
        cur_req = "R10";
        porch_line(8'h40, 30, 0, 255);
        probe();
        porch_line(8'h40, 24, 0, 0);
        probe();

        // PAL: new target and low porch, high end saturates
        do_reset(1'b1);
        cur_req = "R3 R4"; sweep(1'b1, 1);
        cur_req = "R7";
        for (int k = 0; k < 14; k++) begin
            porch_line(8'h10, 16, 0, 0);
            probe();
        end
        cur_req = "R8 R2"; sweep(1'b1, 1);
        cur_req = "R1";    sweep(1'b0, 3);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule